// File: doc/BRIEF.md
# Masked-Write Control Register Bank

This block is a small bank of 32-bit control words sitting behind a single-cycle write/read port. Each word carries a write-enable mask in its upper half and the data in its lower half. A write therefore changes only the data bits whose matching mask bit is set. Software can update one field of a word and leave the other fields alone, with no read-modify-write.

Three control words drive the outputs:
- a per-lane word with four lane-wide groups: lane enable, forced receive mode, forced stop mode and turnaround disable;
- a test-port word with test data, test enable, test clock and test clear;
- a turn word with per-lane turn requests and two clock-invert selects.

A fourth word is read-only and mirrors an 8-bit status input. All control outputs come straight from flip-flops. Read data is returned one cycle after the read request.

Top module: `mwcfg_bank`

## Requirements
- R1: A synchronous active-high reset clears every control output, rd_data and rd_valid to zero.
- R2: On a write to a control word, data bit n (n < 16) takes wr_data[n] only when wr_data[n+16] is 1; every other bit keeps its value.
- R3: The lane word is at word offset 0. Its lower half holds lane_en in bits 3:0, force_rx in 7:4, force_stop in 11:8 and turn_dis in 15:12.
- R4: The test word is at word offset 1. It holds tst_din in bits 7:0, tst_en in bit 8, tst_clk in bit 9 and tst_clr in bit 10. Bits 15:11 are not stored and read as zero.
- R5: The turn word is at word offset 2. It holds turn_req in bits 3:0 and clk_inv[1:0] in bits 11:10. All its other bits are not stored and read as zero.
- R6: The status word is at word offset 4. A read of it returns tst_dout, sampled in the cycle of the read request, in bits 7:0 and zero above. A write to it changes nothing.
- R7: A read raises rd_valid exactly one cycle after rd_en. The read returns the word as it stood in the request cycle, so a write in that same cycle is not yet visible. rd_data[31:16] is always zero, and rd_data is all zero in cycles where rd_valid is low.
- R8: Word offsets 3, 5, 6 and 7 are unmapped. Writes to them change nothing, and reads of them return zero.
- R9: When wr_en is low, no stored bit changes, whatever the values on wr_addr and wr_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, single cycle |
| wr_addr | input | 3 | Write word offset |
| wr_data | input | 32 | Mask in 31:16, data in 15:0 |
| rd_en | input | 1 | Read strobe, single cycle |
| rd_addr | input | 3 | Read word offset |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | High when rd_data holds a read result |
| tst_dout | input | 8 | Status value mirrored by the status word |
| lane_en | output | 4 | Per-lane enable |
| force_rx | output | 4 | Per-lane forced receive mode |
| force_stop | output | 4 | Per-lane forced stop mode |
| turn_dis | output | 4 | Per-lane turnaround disable |
| turn_req | output | 4 | Per-lane turn request |
| clk_inv | output | 2 | Clock-invert selects |
| tst_din | output | 8 | Test data input |
| tst_en | output | 1 | Test enable |
| tst_clk | output | 1 | Test clock |
| tst_clr | output | 1 | Test clear |

## Verification
A read and a write can fall in the same cycle, including to the same word. The bench provokes this both in directed steps and in a long pseudo-random stretch where read and write offsets collide often. The behavioural model forms the expected read value from its state before it applies the write, and it checks that the new value appears on the outputs in that same following cycle. The status input also changes in the cycle of a status read, which pins down the sampling cycle of that path.

// File: rtl/mwcfg_pkg.sv
package mwcfg_pkg;
  localparam int NCTL     = 3;
  localparam int IDX_LANE = 0;
  localparam int IDX_TEST = 1;
  localparam int IDX_TURN = 2;
  localparam int STAT_OFF = 4;

  // Control word k lives at word offset k.
  function automatic int ctl_off(input int k);
    return k;
  endfunction
endpackage

// File: rtl/mwcfg_mreg.sv
module mwcfg_mreg #(
  parameter int HW = 16,
  parameter logic [HW-1:0] IMPL = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2*HW-1:0] wdata,
  output logic [HW-1:0] q
);
  logic [HW-1:0] msk;
  logic [HW-1:0] dat;
  assign msk = wdata[2*HW-1:HW];
  assign dat = wdata[HW-1:0];

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= ((q & ~msk) | (dat & msk)) & IMPL;
  end

  // R2
  masked_bits_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> ((q ^ $past(q)) & ~$past(msk)) == '0);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> q == $past(q));
  // R4
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (q & ~IMPL) == '0);
endmodule

// File: rtl/mwcfg_rdport.sv
module mwcfg_rdport
  import mwcfg_pkg::*;
#(
  parameter int AW  = 3,
  parameter int HW  = 16,
  parameter int TDW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  input  logic [NCTL*HW-1:0] ctl_words,
  input  logic [TDW-1:0]     stat_in,
  output logic [2*HW-1:0]    rd_data,
  output logic               rd_valid
);
  logic [HW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int k = 0; k < NCTL; k++)
      if (rd_addr == AW'(ctl_off(k))) sel = ctl_words[k*HW +: HW];
    if (rd_addr == AW'(STAT_OFF)) sel = {{(HW-TDW){1'b0}}, stat_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? {{HW{1'b0}}, sel} : '0;
    end
  end

  // R7
  rd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R7
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && rd_data == '0));
  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[2*HW-1:HW] == '0);
  // R6
  stat_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == AW'(STAT_OFF)) |=> rd_data == {{(2*HW-TDW){1'b0}}, $past(stat_in)});
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(rd_addr) >= NCTL && rd_addr != AW'(STAT_OFF)) |=> rd_data == '0);
endmodule

// File: rtl/mwcfg_bank.sv
module mwcfg_bank
  import mwcfg_pkg::*;
#(
  parameter int AW    = 3,
  parameter int LANES = 4,
  parameter int TDW   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  input  logic [TDW-1:0]   tst_dout,
  output logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] force_rx,
  output logic [LANES-1:0] force_stop,
  output logic [LANES-1:0] turn_dis,
  output logic [LANES-1:0] turn_req,
  output logic [1:0]       clk_inv,
  output logic [TDW-1:0]   tst_din,
  output logic             tst_en,
  output logic             tst_clk,
  output logic             tst_clr
);
  localparam int HW = 16;
  localparam int LSH = LANES;
  localparam logic [HW-1:0] IMPL_LANE = HW'((32'd1 << (4*LANES)) - 1);
  localparam logic [HW-1:0] IMPL_TEST = HW'((32'd1 << (TDW+3)) - 1);
  localparam logic [HW-1:0] IMPL_TURN = HW'(((32'd1 << LANES) - 1) | 32'h0C00);

  logic [NCTL*HW-1:0] words;

  generate
    for (genvar k = 0; k < NCTL; k++) begin : g_ctl
      localparam logic [HW-1:0] IMPL = (k == IDX_LANE) ? IMPL_LANE :
                                       (k == IDX_TEST) ? IMPL_TEST : IMPL_TURN;
      logic hit;
      assign hit = wr_en && (wr_addr == AW'(ctl_off(k)));
      mwcfg_mreg #(.HW(HW), .IMPL(IMPL)) u_reg (
        .clk(clk), .rst(rst), .we(hit), .wdata(wr_data),
        .q(words[k*HW +: HW])
      );
    end
  endgenerate

  logic [HW-1:0] w_lane, w_test, w_turn;
  assign w_lane = words[IDX_LANE*HW +: HW];
  assign w_test = words[IDX_TEST*HW +: HW];
  assign w_turn = words[IDX_TURN*HW +: HW];

  assign lane_en    = w_lane[0*LSH +: LANES];
  assign force_rx   = w_lane[1*LSH +: LANES];
  assign force_stop = w_lane[2*LSH +: LANES];
  assign turn_dis   = w_lane[3*LSH +: LANES];
  assign tst_din    = w_test[TDW-1:0];
  assign tst_en     = w_test[TDW];
  assign tst_clk    = w_test[TDW+1];
  assign tst_clr    = w_test[TDW+2];
  assign turn_req   = w_turn[LANES-1:0];
  assign clk_inv    = w_turn[11:10];

  mwcfg_rdport #(.AW(AW), .HW(HW), .TDW(TDW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .ctl_words(words), .stat_in(tst_dout),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (lane_en == '0 && force_rx == '0 && force_stop == '0 && turn_dis == '0 &&
             turn_req == '0 && clk_inv == '0 && tst_din == '0 && !tst_en &&
             !tst_clk && !tst_clr && !rd_valid && rd_data == '0));
  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) >= NCTL) |=> words == $past(words));
endmodule

// File: tb/mwcfg_bank_test.sv
module mwcfg_bank_test;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst, wr_en, rd_en;
  logic [2:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic rd_valid;
  logic [7:0] tst_dout;
  logic [3:0] lane_en, force_rx, force_stop, turn_dis, turn_req;
  logic [1:0] clk_inv;
  logic [7:0] tst_din;
  logic tst_en, tst_clk, tst_clr;

  mwcfg_bank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .tst_dout(tst_dout), .lane_en(lane_en), .force_rx(force_rx),
    .force_stop(force_stop), .turn_dis(turn_dis), .turn_req(turn_req),
    .clk_inv(clk_inv), .tst_din(tst_din), .tst_en(tst_en), .tst_clk(tst_clk),
    .tst_clr(tst_clr)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  // behavioural model state
  logic [15:0] m_word [0:2];
  logic [31:0] e_rd;
  logic e_valid;
  logic [31:0] seed = 32'h1234_5678;

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] impl_of(input int k);
    case (k)
      0: return 16'hFFFF;
      1: return 16'h07FF;
      default: return 16'h0C0F;
    endcase
  endfunction

  task automatic step(input string tag);
    @(posedge clk);
    if (rst) begin
      for (int k = 0; k < 3; k++) m_word[k] = 16'h0;
      e_rd = 0; e_valid = 0;
    end else begin
      e_valid = rd_en;
      e_rd = 0;
      if (rd_en) begin
        if (rd_addr < 3) e_rd = {16'h0, m_word[rd_addr]};
        else if (rd_addr == 4) e_rd = {24'h0, tst_dout};
      end
      if (wr_en && wr_addr < 3)
        m_word[wr_addr] = ((m_word[wr_addr] & ~wr_data[31:16]) |
                           (wr_data[15:0] & wr_data[31:16])) & impl_of(int'(wr_addr));
    end
    @(negedge clk);
    cmp({tag, "/R3"}, "lane_en",    {28'h0, lane_en},    {28'h0, m_word[0][3:0]});
    cmp({tag, "/R3"}, "force_rx",   {28'h0, force_rx},   {28'h0, m_word[0][7:4]});
    cmp({tag, "/R3"}, "force_stop", {28'h0, force_stop}, {28'h0, m_word[0][11:8]});
    cmp({tag, "/R3"}, "turn_dis",   {28'h0, turn_dis},   {28'h0, m_word[0][15:12]});
    cmp({tag, "/R4"}, "test",       {21'h0, tst_clr, tst_clk, tst_en, tst_din}, {21'h0, m_word[1][10:0]});
    cmp({tag, "/R5"}, "turn",       {26'h0, clk_inv, turn_req}, {26'h0, m_word[2][11:10], m_word[2][3:0]});
    cmp({tag, "/R7"}, "rd_valid",   {31'h0, rd_valid},  {31'h0, e_valid});
    cmp({tag, "/R7"}, "rd_data",    rd_data, e_rd);
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    idle(); wr_en = 1; wr_addr = a; wr_data = d; step(tag);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    idle(); rd_en = 1; rd_addr = a; step(tag); idle(); step(tag);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(); tst_dout = 8'h00; rst = 1;
    for (int k = 0; k < 3; k++) m_word[k] = 16'h0;
    e_rd = 0; e_valid = 0;
    @(negedge clk);
    step("R1 reset"); step("R1 reset");
    rst = 0;
    // R3 full lane word write, then per-field updates
    wr(3'd0, 32'hFFFF_A5C3, "R3 full write");
    wr(3'd0, 32'h00F0_0070, "R2 one field");
    wr(3'd0, 32'h0000_FFFF, "R2 empty mask");
    wr(3'd0, 32'h8001_0000, "R2 single bits");
    rd(3'd0, "R3 read lane");
    // R4 test word including unstored high bits
    wr(3'd1, 32'hFFFF_FFFF, "R4 all ones");
    rd(3'd1, "R4 read test");
    wr(3'd1, 32'h0200_0000, "R4 clear tst_clk");
    // R5 turn word
    wr(3'd2, 32'hFFFF_FFFF, "R5 all ones");
    rd(3'd2, "R5 read turn");
    wr(3'd2, 32'h0400_0000, "R5 clear inv0");
    // R6 status read, writes ignored
    tst_dout = 8'h5A;
    wr(3'd4, 32'hFFFF_FFFF, "R6 status write");
    rd(3'd4, "R6 status read");
    // R8 unmapped offsets
    wr(3'd3, 32'hFFFF_FFFF, "R8 wr3");
    wr(3'd5, 32'hFFFF_FFFF, "R8 wr5");
    wr(3'd7, 32'hFFFF_FFFF, "R8 wr7");
    rd(3'd3, "R8 rd3"); rd(3'd6, "R8 rd6");
    // R9 wr_en low with live address/data
    idle(); wr_addr = 3'd0; wr_data = 32'hFFFF_0000; step("R9 no strobe");
    // R7 same-cycle read and write to same word
    idle(); wr_en = 1; wr_addr = 3'd0; wr_data = 32'hFFFF_1234;
    rd_en = 1; rd_addr = 3'd0; step("R7 rd+wr same word");
    idle(); step("R7 after");
    // R6 status changes in read cycle
    idle(); rd_en = 1; rd_addr = 3'd4; tst_dout = 8'hC3; step("R6 sample");
    tst_dout = 8'h11; idle(); step("R6 after");
    // mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      seed = nxt(seed);
      wr_en = seed[0]; rd_en = seed[1];
      wr_addr = seed[4:2]; rd_addr = seed[1] & seed[5] ? seed[4:2] : seed[8:6];
      tst_dout = seed[16:9];
      seed = nxt(seed);
      wr_data = seed;
      rst = (i == 300);
      step(rst ? "R1 mid reset" : "R2 random");
    end
    rst = 0; idle(); step("R1 post");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule